// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Bus Read-Out

This block is the digital side of a successive-approximation analog-to-digital converter that hangs off a microprocessor bus. It decodes the chip enable, active-low chip select, read/convert and address-bit inputs into either a conversion request or a data read. It runs the bit trials against a single comparator input, reports a busy status, and presents the result either as one 12-bit word or as two byte-wide reads.

A conversion request is recognised in two situations. The first is when the select becomes active while read/convert is low, which is the bus-driven style. The second is when read/convert falls while the select is already held active, which is the free-running style with enable tied high and select tied low. The address bit captured at that moment chooses between a full 12-bit cycle and a short 8-bit cycle.

The tri-state data bus is modelled as a data vector plus an output-enable flag. The analog comparator, the DAC and the sample-and-hold sit outside the block. The trial code is brought out so that an external comparator can be compared with it.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The block is selected when `ce_i`=1 and `cs_n_i`=0. A conversion starts in two cases: the select becomes active with `rc_i`=0, or `rc_i` falls while the select is held. While selected with `rc_i`=1, the cycle is a read and never starts a conversion.
- R2: A conversion request that arrives while `status_o` is high is discarded. It neither restarts nor lengthens the running conversion, it does not change its length mode, and it does not start a conversion after this one ends.
- R3: If `a0_i`=0 when a conversion starts, 12 bit trials run. If `a0_i`=1, 8 trials run and result bits [3:0] are 0.
- R4: `status_o` rises in the cycle after the start edge. It stays high for SETTLE_CYC + (12 or 8) + LEAD_CYC cycles, then falls.
- R5: With `word12_i`=1, a read drives the whole 12-bit result on `dout_o`.
- R6: With `word12_i`=0 and `a0_i`=0, a read drives result[11:4] on `dout_o[7:0]`. With `a0_i`=1, it drives {result[3:0], 4'b0000} on `dout_o[7:0]`. In both cases `dout_o[11:8]` is 0.
- R7: In the free-running style, `oe_o` is high while `rc_i` is high and no conversion is in progress. `oe_o` drops in the same cycle that `rc_i` falls.
- R8: When `rc_i` is high during a conversion, `oe_o` comes back for the last LEAD_CYC cycles before `status_o` falls. When `rc_i` is low at that point, `oe_o` stays low until `rc_i` next goes high.
- R9: The trials run MSB first, one per clock. Each trial shows the decided bits plus the trial bit on `dac_o`. The bit is kept when `comp_i`=0 and cleared when `comp_i`=1 (DAC above input). With an ideal comparator, the result equals the input code, with the low nibble cleared in short mode.
- R10: `oe_o` is high only while the block is selected with `rc_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read (1) or convert (0) |
| a0_i | input | 1 | Length select at start; byte select at read |
| word12_i | input | 1 | 1: one 12-bit word, 0: two byte reads |
| comp_i | input | 1 | Comparator: 1 when DAC value is above the input |
| dac_o | output | 12 | Trial code presented to the DAC |
| status_o | output | 1 | High while a conversion is running |
| dout_o | output | 12 | Formatted read data |
| oe_o | output | 1 | Data bus drive enable |

## Verification
Random input codes are converted in both length modes, and each result is read back in the word format and in both byte formats. This separates a wrong trial order or a wrong keep/clear rule from a wrong read format. Codes at zero, at full scale and with only the low nibble set separate a short cycle that leaves the low bits untouched from one that resolves them. A convert request injected in mid-conversion with the opposite address bit shows whether the lockout holds. Free-running sequences with a short high pulse, and with read/convert left low, tell apart the two ways the output enable can return.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_TAIL   = 2'd3
    } phase_e;
endpackage

// File: rtl/sar_bus_decode.sv
module sar_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_i,
    input  logic cs_n_i,
    input  logic rc_i,
    input  logic busy_i,
    output logic start_o,
    output logic read_o
);
    typedef struct packed {
        logic sel;
        logic rc;
    } dec_s;

    dec_s q, d;
    logic sel;

    always_comb begin
        sel     = ce_i & ~cs_n_i;
        d.sel   = sel;
        d.rc    = rc_i;
        // new select with convert level, or convert edge under a held select
        start_o = sel & ~rc_i & (~q.sel | q.rc) & ~busy_i;
        read_o  = sel & rc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_ctrl_pkg::*;
#(
    parameter int DW         = 12,
    parameter int SHORT_BITS = 8,
    parameter int SETTLE_CYC = 3,
    parameter int LEAD_CYC   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          a0_i,
    input  logic          comp_i,
    output logic [DW-1:0] dac_o,
    output logic [DW-1:0] result_o,
    output logic          status_o,
    output logic          data_ok_o,
    output logic          short_o
);
    localparam int MAXC = (SETTLE_CYC > LEAD_CYC) ? SETTLE_CYC : LEAD_CYC;
    localparam int CW   = $clog2(MAXC + 1) + 1;
    localparam int IW   = $clog2(DW) + 1;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sar;
        logic          short_mode;
    } seq_s;

    seq_s q, d;
    logic [DW-1:0] trial;
    logic [IW-1:0] stop_idx;

    always_comb begin
        d        = q;
        trial    = DW'(1) << q.idx;
        stop_idx = q.short_mode ? IW'(DW - SHORT_BITS) : '0;
        case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.phase      = PH_SETTLE;
                    d.cnt        = '0;
                    d.idx        = IW'(DW - 1);
                    d.sar        = '0;
                    d.short_mode = a0_i;
                end
            end
            PH_SETTLE: begin
                if (q.cnt == CW'(SETTLE_CYC - 1)) begin
                    d.phase = PH_TRIAL;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_TRIAL: begin
                if (!comp_i) d.sar = q.sar | trial;
                if (q.idx == stop_idx) begin
                    d.phase = PH_TAIL;
                    d.cnt   = '0;
                end else begin
                    d.idx = q.idx - 1'b1;
                end
            end
            default: begin
                if (q.cnt == CW'(LEAD_CYC - 1)) d.phase = PH_IDLE;
                else                            d.cnt   = q.cnt + 1'b1;
            end
        endcase
        dac_o     = (q.phase == PH_TRIAL) ? (q.sar | trial) : q.sar;
        result_o  = q.sar;
        status_o  = (q.phase != PH_IDLE);
        data_ok_o = (q.phase == PH_IDLE) || (q.phase == PH_TAIL);
        short_o   = q.short_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/sar_read_fmt.sv
module sar_read_fmt #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] result_i,
    input  logic          word12_i,
    input  logic          a0_i,
    output logic [DW-1:0] dout_o
);
    localparam int LOW_W = DW - 8;

    logic [7:0] hi_byte, lo_byte;

    always_comb begin
        hi_byte = result_i[DW-1 -: 8];
        lo_byte = 8'(result_i[LOW_W-1:0]) << (8 - LOW_W);
        if (word12_i)  dout_o = result_i;
        else if (a0_i) dout_o = DW'(lo_byte);
        else           dout_o = DW'(hi_byte);
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int DW         = 12,
    parameter int SHORT_BITS = 8,
    parameter int SETTLE_CYC = 3,
    parameter int LEAD_CYC   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_i,
    input  logic          cs_n_i,
    input  logic          rc_i,
    input  logic          a0_i,
    input  logic          word12_i,
    input  logic          comp_i,
    output logic [DW-1:0] dac_o,
    output logic          status_o,
    output logic [DW-1:0] dout_o,
    output logic          oe_o
);
    logic          start_w, read_w, data_ok_w, short_w;
    logic [DW-1:0] result_w;

    sar_bus_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .cs_n_i(cs_n_i), .rc_i(rc_i),
        .busy_i(status_o), .start_o(start_w), .read_o(read_w)
    );

    sar_seq #(
        .DW(DW), .SHORT_BITS(SHORT_BITS), .SETTLE_CYC(SETTLE_CYC), .LEAD_CYC(LEAD_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .a0_i(a0_i), .comp_i(comp_i),
        .dac_o(dac_o), .result_o(result_w), .status_o(status_o),
        .data_ok_o(data_ok_w), .short_o(short_w)
    );

    sar_read_fmt #(.DW(DW)) u_fmt (
        .result_i(result_w), .word12_i(word12_i), .a0_i(a0_i), .dout_o(dout_o)
    );

    assign oe_o = read_w & data_ok_w;
endmodule

// File: rtl/sar_ctrl_checker.sv
module sar_ctrl_checker #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_i,
    input logic          cs_n_i,
    input logic          rc_i,
    input logic          a0_i,
    input logic          word12_i,
    input logic          status_o,
    input logic          oe_o,
    input logic [DW-1:0] dout_o,
    input logic          start_w,
    input logic          short_w,
    input logic [DW-1:0] result_w
);
    a_r10_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> (ce_i && !cs_n_i && rc_i));

    a_r4_status_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> status_o);

    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && $past(status_o)) |-> $stable(short_w));

    a_r3_short_pad: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(status_o) && short_w) |-> (result_w[3:0] == 4'b0000));

    a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && !word12_i) |-> (dout_o[DW-1:8] == '0));

    a_r6_low_byte_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && !word12_i && a0_i) |-> (dout_o[3:0] == 4'b0000));

    a_r7_oe_drops_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rc_i) && ce_i && !cs_n_i) |-> !oe_o);
endmodule

bind sar_adc_ctrl sar_ctrl_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .cs_n_i(cs_n_i), .rc_i(rc_i),
    .a0_i(a0_i), .word12_i(word12_i), .status_o(status_o), .oe_o(oe_o),
    .dout_o(dout_o), .start_w(start_w), .short_w(short_w), .result_w(result_w)
);

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
    localparam int DW = 12, SETTLE = 3, LEAD = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce = 1'b0, cs_n = 1'b1, rc = 1'b1, a0 = 1'b0, w12 = 1'b1;
    logic comp;
    logic [DW-1:0] dac, dout;
    logic status, oe;
    int vin = 0;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign comp = (int'(dac) > vin);

    sar_adc_ctrl #(.DW(DW), .SHORT_BITS(8), .SETTLE_CYC(SETTLE), .LEAD_CYC(LEAD)) u_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .cs_n_i(cs_n), .rc_i(rc), .a0_i(a0),
        .word12_i(w12), .comp_i(comp), .dac_o(dac), .status_o(status),
        .dout_o(dout), .oe_o(oe)
    );

    function automatic int exp_res(int v, bit sh);
        return sh ? (v & 12'hFF0) : (v & 12'hFFF);
    endfunction

    function automatic int exp_fmt(int r, bit wide, bit lo);
        if (wide) return r;
        if (lo)   return (r & 4'hF) << 4;
        return (r >> 4) & 8'hFF;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // full-control convert: select pulse with rc low
    task automatic convert(int v, bit sh, output int len);
        vin = v;
        @(negedge clk); rc = 1'b0; a0 = sh; ce = 1'b1; cs_n = 1'b0;
        @(negedge clk); ce = 1'b0; cs_n = 1'b1; rc = 1'b1;
        len = 0;
        while (status) begin len++; @(negedge clk); end
    endtask

    task automatic read(bit wide, bit lo, output int data, output bit en);
        @(negedge clk); rc = 1'b1; ce = 1'b1; cs_n = 1'b0; w12 = wide; a0 = lo;
        #1; data = int'(dout); en = oe;
        @(negedge clk); ce = 1'b0; cs_n = 1'b1;
    endtask

    task automatic read_all(int r, string tag);
        int d; bit e;
        read(1'b1, 1'b0, d, e); check({tag, " R5 word"}, d, exp_fmt(r, 1, 0));
        check({tag, " R10 oe on read"}, int'(e), 1);
        read(1'b0, 1'b0, d, e); check({tag, " R6 msb byte"}, d, exp_fmt(r, 0, 0));
        read(1'b0, 1'b1, d, e); check({tag, " R6 lsb byte"}, d, exp_fmt(r, 0, 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int len, d, cnt_ov;
        bit e, sh;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R4 reset status", int'(status), 0);
        check("R10 reset oe", int'(oe), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: read cycle while selected never starts conversion
        read(1'b1, 1'b0, d, e);
        @(negedge clk); check("R1 read no start", int'(status), 0);

        // directed corners, R3/R9/R4
        convert(12'hFFF, 1'b0, len); check("R4 len12", len, SETTLE + 12 + LEAD);
        read_all(exp_res(12'hFFF, 0), "full");
        convert(0, 1'b0, len); read_all(0, "zero");
        convert(12'h00F, 1'b1, len); check("R4 len8", len, SETTLE + 8 + LEAD);
        read_all(exp_res(12'h00F, 1), "R3 short lownib");
        convert(12'hA5C, 1'b1, len); read_all(exp_res(12'hA5C, 1), "R3 short");

        // R2: lockout with opposite A0 in mid-conversion
        vin = 12'h3C7;
        @(negedge clk); rc = 1'b0; a0 = 1'b0; ce = 1'b1; cs_n = 1'b0;
        @(negedge clk); ce = 1'b0; cs_n = 1'b1;
        len = 0;
        repeat (4) begin len++; @(negedge clk); end
        a0 = 1'b1; ce = 1'b1; cs_n = 1'b0;
        @(negedge clk); ce = 1'b0; cs_n = 1'b1; rc = 1'b1; len++;
        while (status) begin len++; @(negedge clk); end
        check("R2 length unchanged", len, SETTLE + 12 + LEAD);
        repeat (3) @(negedge clk);
        check("R2 no deferred start", int'(status), 0);
        read_all(exp_res(12'h3C7, 0), "R2 result");

        // R7/R8 free-running, short low pulse on rc
        vin = 12'h5A3;
        @(negedge clk); w12 = 1'b1; a0 = 1'b0; rc = 1'b1; ce = 1'b1; cs_n = 1'b0;
        #1; check("R7 oe while rc high", int'(oe), 1);
        @(negedge clk); rc = 1'b0;
        #1; check("R7 oe drops on fall", int'(oe), 0);
        @(negedge clk); rc = 1'b1;
        check("R7 start on fall", int'(status), 1);
        cnt_ov = 0;
        while (status) begin
            #1; if (oe) cnt_ov++;
            @(negedge clk);
        end
        check("R8 oe lead cycles", cnt_ov, LEAD);
        #1; check("R8 oe after done", int'(oe), 1);
        check("R9 free-running result", int'(dout), 12'h5A3);

        // R8 rc left low: outputs stay off until rc rises
        vin = 12'h123;
        @(negedge clk); rc = 1'b0;
        @(negedge clk);
        while (status) @(negedge clk);
        #1; check("R8 oe off with rc low", int'(oe), 0);
        @(negedge clk); rc = 1'b1;
        #1; check("R8 oe on rc high", int'(oe), 1);
        check("R1 rc falling start result", int'(dout), 12'h123);
        @(negedge clk); ce = 1'b0; cs_n = 1'b1;

        // random mix
        for (int i = 0; i < 24; i++) begin
            int v;
            v = int'($urandom % 4096);
            sh = 1'($urandom % 2);
            convert(v, sh, len);
            check("R4 random length", len, SETTLE + (sh ? 8 : 12) + LEAD);
            read_all(exp_res(v, sh), "R9 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule